// File: doc/BRIEF.md
# Converter Result Transfer Controller

This block sits between a sampling converter's result register and a small single-channel DMA engine, which is built into it. Each time the converter strobes a fresh result word, the controller captures it and holds a transfer request toward the engine until the engine accepts it. The engine writes the words to a buffer in memory. It keeps a programmable transfer count and a destination pointer, and it marks the end of the programmed block with a one-cycle pulse.

A mode input picks between two behaviours. In block mode, the controller stops raising requests once the final programmed transfer has been accepted. It also raises a halt level so that the converter stops, and any result that arrives after that point is dropped. In ring mode, the engine reloads its count and its pointer when the block ends, and requests carry on without a break. The buffer then fills as a ring, which suits an unbroken stream of samples.

Dropping the enable input, or asserting the synchronous reset, returns the block to a clean state: no request pending, no error flag, no halt. The next enable loads the count and the base address again.

Top module: `cnv_dma_link`

## Requirements
- R1: While `rst` is high and at the first sample after it, `wr_valid`, `overrun`, `eot_pulse` and `conv_halt` are all 0.
- R2: A `res_valid` strobe accepted at a clock edge makes `wr_valid` 1 from that edge on, with `wr_data` equal to the strobed word. The request stays high, with unchanged data, until an edge at which `wr_ready` is 1 (the acknowledge).
- R3: After an enable, the first transfer is presented at `wr_addr` = `buf_base`. Each acknowledge moves `wr_addr` up by WORD_BYTES, except where R6 returns it to the base.
- R4: `eot_pulse` is 1 for exactly the one cycle after the acknowledge that completes the `xfer_total`-th transfer of a block, and 0 in every other cycle.
- R5: With `ring_mode` = 0 (block mode), `conv_halt` becomes 1 from the edge of the final acknowledge onward. No result strobed at that edge or later raises a request, so exactly `xfer_total` words are transferred.
- R6: With `ring_mode` = 1 (ring mode), the final acknowledge of a block sets `wr_addr` back to `buf_base` and reloads the count. Requests continue past every block end, and `conv_halt` stays 0.
- R7: A result strobed while a request is pending and not being acknowledged at that edge sets `overrun`, which then stays 1. `wr_data` takes the newer word, and only one transfer is made for the two words.
- R8: A result strobed at the same edge as an acknowledge becomes the new pending request and does not set `overrun`.
- R9: An edge at which `enable` is 0 clears the pending request, `overrun`, `eot_pulse` and `conv_halt`. It also loads `xfer_total` and `buf_base`, so the next block starts anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low clears and reloads the block |
| ring_mode | input | 1 | 0 = block (stop at end), 1 = ring (wrap at end) |
| xfer_total | input | CNT_W | Transfers per block, at least 1; loaded while disabled |
| buf_base | input | ADDR_W | Buffer start address; loaded while disabled |
| res_valid | input | 1 | One-cycle strobe: new converter result word |
| res_data | input | DATA_W | Converter result word |
| wr_valid | output | 1 | Transfer request, held until acknowledged |
| wr_addr | output | ADDR_W | Destination address of the pending transfer |
| wr_data | output | DATA_W | Word to transfer |
| wr_ready | input | 1 | Transfer acknowledge |
| eot_pulse | output | 1 | One-cycle end-of-block pulse |
| conv_halt | output | 1 | Stop request toward the converter (block mode done) |
| overrun | output | 1 | Sticky flag: a pending word was overwritten |

## Verification
The hardest corner is a result that arrives at the same edge as the final block-mode acknowledge. A design that still admits it would make one transfer too many and would write past the buffer. The bench also aims at an acknowledge and a strobe landing together, where a careless pending flag either drops the new word or raises a false overrun. A one-word ring with a strobe and an acknowledge on every cycle checks that the pointer never leaves the base and that the end pulse fires on each cycle; an off-by-one in the count reload would show up there as a step in the address or as a missing pulse. Random runs in both modes compare every request, address, flag and pulse against a transaction model. A disable in the middle of a run is checked to leave no stale request or flag behind.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

   typedef enum logic {
      MODE_BLOCK = 1'b0,
      MODE_RING  = 1'b1
   } ring_mode_e;

   function automatic logic is_ring(input logic mode_bit);
      return ring_mode_e'(mode_bit) == MODE_RING;
   endfunction

endpackage

// File: rtl/cdl_req_slot.sv
module cdl_req_slot #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              accept_ok,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              ack,
   output logic              pend,
   output logic [DATA_W-1:0] data,
   output logic              ovr
);

   logic              pend_q;
   logic              ovr_q;
   logic [DATA_W-1:0] data_q;
   logic              take;

   assign take = res_valid && accept_ok;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         pend_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (take) begin
         pend_q <= 1'b1;
         if (pend_q && !ack) begin
            ovr_q <= 1'b1;
         end
      end else if (ack) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
      end else if (en && take) begin
         data_q <= res_data;
      end
   end

   assign pend = pend_q;
   assign data = data_q;
   assign ovr  = ovr_q;

endmodule

// File: rtl/cdl_xfer_engine.sv
module cdl_xfer_engine #(
   parameter int CNT_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              ring,
   input  logic [CNT_W-1:0]  cnt_cfg,
   input  logic [ADDR_W-1:0] base_cfg,
   input  logic              ack,
   output logic [ADDR_W-1:0] addr,
   output logic              last_ack,
   output logic              eot_pulse,
   output logic              done
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(1);

   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nx;
   logic              eot_q;
   logic              done_q;

   assign last_ack = ack && (left_q == LAST_CNT);

   generate
      if (WORD_BYTES == 1) begin : g_unit_step
         assign addr_nx = addr_q + ADDR_W'(1);
      end else begin : g_word_step
         localparam int STEP_SH = $clog2(WORD_BYTES);
         localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SH;
         assign addr_nx = addr_q + STEP;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         left_q <= cnt_cfg;
         addr_q <= base_cfg;
         eot_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         eot_q <= last_ack;
         if (last_ack) begin
            if (ring) begin
               left_q <= cnt_cfg;
               addr_q <= base_cfg;
            end else begin
               left_q <= '0;
               addr_q <= addr_nx;
               done_q <= 1'b1;
            end
         end else if (ack) begin
            left_q <= left_q - LAST_CNT;
            addr_q <= addr_nx;
         end
      end
   end

   assign addr      = addr_q;
   assign eot_pulse = eot_q;
   assign done      = done_q;

endmodule

// File: rtl/cnv_dma_link.sv
module cnv_dma_link #(
   parameter int DATA_W     = 12,
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 8,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              ring_mode,
   input  logic [CNT_W-1:0]  xfer_total,
   input  logic [ADDR_W-1:0] buf_base,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic              eot_pulse,
   output logic              conv_halt,
   output logic              overrun
);

   generate
      if (DATA_W < 1 || ADDR_W < 2 || CNT_W < 1) begin : g_bad_width
         $error("cnv_dma_link: width parameter out of range");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_step
         $error("cnv_dma_link: WORD_BYTES must be a power of two");
      end
   endgenerate

   logic ring;
   logic pend;
   logic ack;
   logic last_ack;
   logic done;
   logic accept_ok;

   assign ring      = cdl_pkg::is_ring(ring_mode);
   assign ack       = pend && wr_ready;
   assign accept_ok = ring || !(done || last_ack);

   cdl_req_slot #(
      .DATA_W(DATA_W)
   ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .en       (enable),
      .accept_ok(accept_ok),
      .res_valid(res_valid),
      .res_data (res_data),
      .ack      (ack),
      .pend     (pend),
      .data     (wr_data),
      .ovr      (overrun)
   );

   cdl_xfer_engine #(
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .WORD_BYTES(WORD_BYTES)
   ) u_engine (
      .clk      (clk),
      .rst      (rst),
      .en       (enable),
      .ring     (ring),
      .cnt_cfg  (xfer_total),
      .base_cfg (buf_base),
      .ack      (ack),
      .addr     (wr_addr),
      .last_ack (last_ack),
      .eot_pulse(eot_pulse),
      .done     (done)
   );

   assign wr_valid  = pend;
   assign conv_halt = done;

endmodule

// File: rtl/cnv_dma_link_chk.sv
module cnv_dma_link_chk #(
   parameter int DATA_W     = 12,
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 8,
   parameter int WORD_BYTES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              enable,
   input logic              ring_mode,
   input logic [CNT_W-1:0]  xfer_total,
   input logic [ADDR_W-1:0] buf_base,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ready,
   input logic              eot_pulse,
   input logic              conv_halt,
   input logic              overrun
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready && enable) |=> wr_valid);

   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready && enable && !res_valid) |=> $stable(wr_data));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready && enable) |=>
         ((wr_addr == $past(wr_addr) + STEP) || (wr_addr == $past(buf_base))));

   // R4
   eot_cause_chk: assert property (@(posedge clk) disable iff (rst)
      eot_pulse |-> $past(wr_valid && wr_ready && enable));

   // R5
   halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      conv_halt |-> !wr_valid);

   // R7
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (overrun && enable) |=> overrun);

   // R9
   disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !enable |=> (!wr_valid && !overrun && !eot_pulse && !conv_halt));

endmodule

bind cnv_dma_link cnv_dma_link_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .CNT_W     (CNT_W),
   .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/test_cnv_dma_link.sv
module test_cnv_dma_link;

   localparam int DATA_W = 12;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 8;
   localparam int WB     = 2;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              enable = 1'b0;
   logic              ring_mode = 1'b0;
   logic [CNT_W-1:0]  xfer_total = 8'd5;
   logic [ADDR_W-1:0] buf_base = 16'h1000;
   logic              res_valid = 1'b0;
   logic [DATA_W-1:0] res_data = '0;
   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              wr_ready = 1'b0;
   logic              eot_pulse;
   logic              conv_halt;
   logic              overrun;

   cnv_dma_link #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WB))
   i_cnv_dma_link (
      .clk(clk), .rst(rst), .enable(enable), .ring_mode(ring_mode),
      .xfer_total(xfer_total), .buf_base(buf_base),
      .res_valid(res_valid), .res_data(res_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .eot_pulse(eot_pulse), .conv_halt(conv_halt), .overrun(overrun)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit model_on = 1'b0;

   // transaction model state
   bit              m_pend, m_ovr, m_eot, m_done;
   int              m_left;
   logic [ADDR_W-1:0] m_addr;
   logic [DATA_W-1:0] m_data;
   int              m_acks;
   int              m_eots;

   function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
      return a + ADDR_W'(WB);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 100000);
         finish_run();
      end
   end

   // model advance at each edge from the inputs the bench drives
   always @(posedge clk) begin
      bit ack, last, allow, old_done;
      if (rst || !enable) begin
         m_pend = 0; m_ovr = 0; m_eot = 0; m_done = 0;
         m_left = int'(xfer_total); m_addr = buf_base;
      end else begin
         old_done = m_done;
         ack  = m_pend && wr_ready;
         last = ack && (m_left == 1);
         m_eot = last;
         if (ack) begin
            m_acks++;
            if (last) begin
               m_eots++;
               if (ring_mode) begin
                  m_left = int'(xfer_total); m_addr = buf_base;
               end else begin
                  m_left = 0; m_addr = next_addr(m_addr); m_done = 1;
               end
            end else begin
               m_left--; m_addr = next_addr(m_addr);
            end
         end
         allow = ring_mode || !(old_done || last);
         if (res_valid && allow) begin
            if (m_pend && !ack) m_ovr = 1;
            m_pend = 1; m_data = res_data;
         end else if (ack) begin
            m_pend = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         chk("R2 wr_valid", 32'(wr_valid), 32'(m_pend));
         if (m_pend) chk("R2 wr_data", 32'(wr_data), 32'(m_data));
         chk("R3 wr_addr", 32'(wr_addr), 32'(m_addr));
         chk("R4 eot_pulse", 32'(eot_pulse), 32'(m_eot));
         chk("R5 conv_halt", 32'(conv_halt), 32'(m_done));
         chk("R7 overrun", 32'(overrun), 32'(m_ovr));
      end
   end

   task automatic step(input bit rv, input logic [DATA_W-1:0] rd, input bit rdy);
      res_valid = rv; res_data = rd; wr_ready = rdy;
      @(negedge clk);
   endtask

   task automatic restart(input bit ring, input int n, input logic [ADDR_W-1:0] base);
      enable = 1'b0; res_valid = 1'b0; wr_ready = 1'b0;
      @(negedge clk);
      ring_mode = ring; xfer_total = CNT_W'(n); buf_base = base;
      @(negedge clk);
      enable = 1'b1;
      m_acks = 0; m_eots = 0;
   endtask

   task automatic run_random(input int cycles, input int rv_pct, input int rdy_pct);
      for (int i = 0; i < cycles; i++) begin
         step(($urandom % 100) < rv_pct, DATA_W'($urandom), ($urandom % 100) < rdy_pct);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 wr_valid", 32'(wr_valid), 0);
      chk("R1 overrun", 32'(overrun), 0);
      chk("R1 eot_pulse", 32'(eot_pulse), 0);
      chk("R1 conv_halt", 32'(conv_halt), 0);
      rst = 1'b0;
      model_on = 1'b1;

      // block mode, 5 transfers, random traffic (R5)
      restart(1'b0, 5, 16'h1000);
      run_random(150, 40, 50);
      chk("R5 halt after block", 32'(conv_halt), 1);
      chk("R5 transfer count", 32'(m_acks), 5);
      chk("R4 end pulses", 32'(m_eots), 1);

      // overrun and overlap (R7, R8), then disable clear (R9)
      restart(1'b0, 5, 16'h2000);
      step(1'b1, 12'hAAA, 1'b0);
      step(1'b1, 12'hBBB, 1'b0);
      chk("R7 overrun set", 32'(overrun), 1);
      chk("R7 newer word kept", 32'(wr_data), 32'h0BBB);
      step(1'b0, 12'h000, 1'b1);
      chk("R7 single transfer", 32'(m_acks), 1);
      chk("R7 request dropped", 32'(wr_valid), 0);
      restart(1'b0, 5, 16'h2000);
      step(1'b1, 12'h111, 1'b0);
      step(1'b1, 12'h222, 1'b1);
      chk("R8 new pending", 32'(wr_valid), 1);
      chk("R8 new data", 32'(wr_data), 32'h0222);
      chk("R8 no overrun", 32'(overrun), 0);
      step(1'b1, 12'h333, 1'b0);
      chk("R8 overrun after real clash", 32'(overrun), 1);
      enable = 1'b0;
      step(1'b0, 12'h000, 1'b0);
      chk("R9 request cleared", 32'(wr_valid), 0);
      chk("R9 overrun cleared", 32'(overrun), 0);
      chk("R9 base reloaded", 32'(wr_addr), 32'h2000);

      // ring mode, 3 per block, random (R6)
      restart(1'b1, 3, 16'h3000);
      run_random(300, 50, 60);
      chk("R6 no halt in ring", 32'(conv_halt), 0);
      chk("R6 continues past blocks", 32'(m_acks > 9), 1);
      chk("R6 several wraps", 32'(m_eots >= 3), 1);

      // ring mode, 1 per block, full rate
      restart(1'b1, 1, 16'h4000);
      for (int i = 0; i < 20; i++) step(1'b1, DATA_W'(i), 1'b1);
      chk("R6 addr pinned at base", 32'(wr_addr), 32'h4000);
      chk("R4 pulse each transfer", 32'(m_eots), 32'(m_acks));

      // block mode, 1 transfer, strobe on the last acknowledge edge
      restart(1'b0, 1, 16'h5000);
      for (int i = 0; i < 10; i++) step(1'b1, DATA_W'(12'h700 + i), 1'b1);
      chk("R5 one word only", 32'(m_acks), 1);
      chk("R5 no late request", 32'(wr_valid), 0);
      chk("R5 halted", 32'(conv_halt), 1);

      // block mode, mixed rates
      restart(1'b0, 7, 16'h6000);
      run_random(200, 70, 30);
      chk("R5 block total", 32'(m_acks), 7);

      res_valid = 1'b0; wr_ready = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule